// File: doc/BRIEF.md
# Burst Write Packet Segmenter

This block sits between a memory-mapped write slave with 64-bit data beats and a packet builder for PCI Express memory writes. It takes in a whole write burst of up to 64 beats (512 bytes), checks the byte-enable pattern, and then cuts the burst into packets. A packet ends at the first of three limits: the next 4 KB address boundary, the maximum payload size picked by a static setting, or the end of the burst. For each packet it presents a descriptor, then the packet's payload beats on a separate data stream.

The descriptor holds the dword-aligned start address, the length in dwords, the byte enables of the first and last dword, and a flag that selects the 64-bit address format. The whole burst is held in local storage before any packet leaves. A burst that breaks the byte-enable rule, or that carries an illegal beat count, is therefore dropped whole and never partly sent. A sticky error flag records the drop.

The input port takes the address and the beat count on the first beat of a burst. Address bits 2:0 are ignored. The input stalls for as long as packets of the previous burst are still leaving.

Top module: `wr_burst_segmenter`

## Requirements
- R1: Bursts of 1 to 64 beats are taken beat by beat. `in_ready_o` is high whenever no packet is pending, and each burst is fully collected before its first descriptor appears.
- R2: No packet covers bytes on both sides of a 4 KB boundary. Start address bits 11:0 plus four times the length never exceed 4096.
- R3: No packet is longer than the maximum payload. `mps_sel_i` value 0 selects 128 bytes, 1 selects 256, 2 selects 512, and 3 selects 128.
- R4: Packets are cut greedily, in address order. Each packet spans the largest number of beats allowed by the remaining beats, the room left in the current 4 KB page, and the payload limit.
- R5: The descriptor address is the byte address of the first dword in the packet that holds an enabled byte, and the length runs to the last such dword. The first/last byte enables are those of those two dwords, with low dword = beat byte enables 3:0 and high dword = 7:4. The last byte enable is 0 for a one-dword packet. A single beat with no enabled byte gives length 1, first byte enable 0, at the beat's low dword.
- R6: `desc_is64_o` is 1 exactly when bits 63:32 of the packet's start address are not all zero. A burst that runs across the 4 GB line switches format between its packets.
- R7: After each accepted descriptor come exactly its payload beats, in order, carrying the original data and byte enables, with `dat_last_o` high on the final beat only.
- R8: In a burst of more than one beat, every beat but the last must have byte enables 8'hFF, and the last must be nonzero and contiguous from bit 0. A burst count of 0 (one beat consumed) or above 64 is illegal. Any of these faults causes the burst to be dropped without output and raises `err_o`.
- R9: `err_o` stays high once set until reset, and bursts that follow are still handled normally. Legal traffic never sets it.
- R10: While a valid output is not accepted, it and all its fields hold steady. `in_ready_o` is low while either output is valid.
- R11: During and right after reset, no output is valid, `err_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mps_sel_i | input | 2 | Static maximum payload setting |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high |
| in_addr_i | input | 64 | Burst byte address, read on the first beat |
| in_beats_i | input | CNT_W (7) | Burst beat count, read on the first beat |
| in_data_i | input | 64 | Beat data |
| in_be_i | input | 8 | Beat byte enables |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Descriptor accepted |
| desc_addr_o | output | 64 | Packet start byte address (dword aligned) |
| desc_len_o | output | 10 | Packet length in dwords |
| desc_fbe_o | output | 4 | First dword byte enables |
| desc_lbe_o | output | 4 | Last dword byte enables |
| desc_is64_o | output | 1 | 64-bit address format |
| dat_valid_o | output | 1 | Payload beat valid |
| dat_ready_i | input | 1 | Payload beat accepted |
| dat_o | output | 64 | Payload data |
| dat_be_o | output | 8 | Payload byte enables |
| dat_last_o | output | 1 | Final payload beat of the packet |
| err_o | output | 1 | Sticky dropped-burst flag |

## Verification
The sweep starts bursts a few qwords before a 4 KB boundary and just under the 4 GB line, at lengths on either side of each payload limit. An off-by-one in the page-room arithmetic would let a packet overrun the boundary or leave an empty packet, and an address-format flag latched once per burst would mislabel the second packet. Every single-beat byte-enable value and every last-beat value of a two-beat burst are tried. A design that got the edge-dword logic wrong would report a wrong start dword, length or last byte enable, and a lax rule checker would send bursts it should drop. Random back-pressure on both outputs shows whether the fields move while they are held.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;

  localparam int LEN_W     = 10;
  localparam int PAGE_QW   = 512;   // qwords in a 4 KB page

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DESC    = 2'd1,
    ST_DATA    = 2'd2
  } wbs_state_e;

  typedef struct packed {
    logic             skip_low;
    logic [LEN_W-1:0] len;
    logic [3:0]       fbe;
    logic [3:0]       lbe;
  } edge_t;

  // payload limit in qwords for the static setting
  function automatic logic [9:0] mps_qwords(input logic [1:0] sel);
    case (sel)
      2'd1:    return 10'd32;
      2'd2:    return 10'd64;
      default: return 10'd16;
    endcase
  endfunction

  // beats in the next packet: least of remaining, page room, payload limit
  function automatic logic [9:0] seg_qwords(input logic [8:0] page_off,
                                            input logic [9:0] rem,
                                            input logic [9:0] lim);
    logic [9:0] room;
    logic [9:0] n;
    room = 10'(PAGE_QW) - {1'b0, page_off};
    n = rem;
    if (room < n) n = room;
    if (lim < n)  n = lim;
    return n;
  endfunction

  // dword length and edge byte enables from the edge beats of a packet
  function automatic edge_t edge_fields(input logic [9:0] nb,
                                        input logic [7:0] fb,
                                        input logic [7:0] lb);
    edge_t e;
    logic  skip_high;
    e.skip_low = (fb[3:0] == 4'd0);
    skip_high  = (lb[7:4] == 4'd0);
    e.len = (nb << 1) - {9'd0, e.skip_low} - {9'd0, skip_high};
    if (e.len == '0) begin
      e.len      = 10'd1;
      e.skip_low = 1'b0;
      e.fbe      = 4'd0;
      e.lbe      = 4'd0;
    end else begin
      e.fbe = e.skip_low ? fb[7:4] : fb[3:0];
      e.lbe = (e.len == 10'd1) ? 4'd0 : (skip_high ? lb[3:0] : lb[7:4]);
    end
    return e;
  endfunction

endpackage

// File: rtl/wbs_beat_store.sv
`timescale 1ns/1ps
module wbs_beat_store #(
  parameter  int DEPTH = 64,
  parameter  int W     = 72,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/wbs_be_rule.sv
`timescale 1ns/1ps
module wbs_be_rule #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] idx_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [7:0]       be_i,
  output logic             bad_o
);

  always_comb begin
    bad_o = 1'b0;
    if (total_i > CNT_W'(1)) begin
      if (idx_i == total_i - CNT_W'(1))
        // last beat: nonzero and contiguous from bit 0
        bad_o = (be_i == 8'd0) || ((be_i & (be_i + 8'd1)) != 8'd0);
      else
        bad_o = (be_i != 8'hFF);
    end
  end

endmodule

// File: rtl/wbs_seg_plan.sv
`timescale 1ns/1ps
module wbs_seg_plan
  import wbs_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [60:0]      qaddr_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic             first_i,
  input  logic [7:0]       be_first_i,
  input  logic [7:0]       be_last_i,
  input  logic [1:0]       mps_sel_i,
  output logic [CNT_W-1:0] nb_o,
  output logic             last_o,
  output logic [63:0]      addr_o,
  output logic [LEN_W-1:0] len_o,
  output logic [3:0]       fbe_o,
  output logic [3:0]       lbe_o,
  output logic             is64_o
);

  logic [9:0] nb10;
  logic [7:0] fb_raw, lb_raw, fb, lb;
  edge_t      ed;

  always_comb begin
    nb10   = seg_qwords(qaddr_i[8:0], 10'(rem_i), mps_qwords(mps_sel_i));
    nb_o   = CNT_W'(nb10);
    last_o = (nb10 == 10'(rem_i));
    fb_raw = first_i ? be_first_i : 8'hFF;
    lb_raw = last_o  ? be_last_i  : 8'hFF;
    if (nb10 == 10'd1) begin
      fb = fb_raw & lb_raw;
      lb = fb_raw & lb_raw;
    end else begin
      fb = fb_raw;
      lb = lb_raw;
    end
    ed     = edge_fields(nb10, fb, lb);
    addr_o = {qaddr_i, ed.skip_low, 2'b00};
    len_o  = ed.len;
    fbe_o  = ed.fbe;
    lbe_o  = ed.lbe;
    is64_o = |addr_o[63:32];
  end

endmodule

// File: rtl/wr_burst_segmenter.sv
`timescale 1ns/1ps
module wr_burst_segmenter
  import wbs_pkg::*;
#(
  parameter  int MAX_BEATS = 64,
  localparam int CNT_W     = $clog2(MAX_BEATS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mps_sel_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [63:0]      in_addr_i,
  input  logic [CNT_W-1:0] in_beats_i,
  input  logic [63:0]      in_data_i,
  input  logic [7:0]       in_be_i,
  output logic             desc_valid_o,
  input  logic             desc_ready_i,
  output logic [63:0]      desc_addr_o,
  output logic [9:0]       desc_len_o,
  output logic [3:0]       desc_fbe_o,
  output logic [3:0]       desc_lbe_o,
  output logic             desc_is64_o,
  output logic             dat_valid_o,
  input  logic             dat_ready_i,
  output logic [63:0]      dat_o,
  output logic [7:0]       dat_be_o,
  output logic             dat_last_o,
  output logic             err_o
);

  localparam int IDX_W = $clog2(MAX_BEATS);
  localparam int ENT_W = 72;

  wbs_state_e       st_q;
  logic [CNT_W-1:0] idx_q, cnt_q, rem_q, left_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic [60:0]      qaddr_q;
  logic [7:0]       be_first_q, be_last_q;
  logic             bad_q, err_q;

  // named events
  logic             beat_acc, desc_fire, dat_fire, burst_drop, burst_keep;
  logic [CNT_W-1:0] cnt_now;
  logic             last_now, rule_bad, count_bad, bad_now;
  logic             addr_lo_unused;

  logic [CNT_W-1:0] nb_w;
  logic             seg_last_w;
  logic [ENT_W-1:0] rd_ent;

  assign addr_lo_unused = ^in_addr_i[2:0];

  assign in_ready_o   = (st_q == ST_COLLECT);
  assign desc_valid_o = (st_q == ST_DESC);
  assign dat_valid_o  = (st_q == ST_DATA);
  assign err_o        = err_q;

  assign beat_acc  = in_valid_i && in_ready_o;
  assign desc_fire = desc_valid_o && desc_ready_i;
  assign dat_fire  = dat_valid_o && dat_ready_i;

  assign cnt_now   = (idx_q == '0) ? in_beats_i : cnt_q;
  assign last_now  = (cnt_now == '0) || (idx_q == cnt_now - CNT_W'(1));
  assign count_bad = (cnt_now == '0) || (cnt_now > CNT_W'(MAX_BEATS));
  assign bad_now   = bad_q || rule_bad || count_bad;
  assign burst_drop = beat_acc && last_now && bad_now;
  assign burst_keep = beat_acc && last_now && !bad_now;

  wbs_be_rule #(.CNT_W(CNT_W)) u_rule (
    .idx_i   (idx_q),
    .total_i (cnt_now),
    .be_i    (in_be_i),
    .bad_o   (rule_bad)
  );

  wbs_beat_store #(.DEPTH(MAX_BEATS), .W(ENT_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (beat_acc && (idx_q < CNT_W'(MAX_BEATS))),
    .waddr_i (idx_q[IDX_W-1:0]),
    .wdata_i ({in_data_i, in_be_i}),
    .raddr_i (rd_idx_q),
    .rdata_o (rd_ent)
  );

  assign {dat_o, dat_be_o} = rd_ent;
  assign dat_last_o = (left_q == CNT_W'(1));

  wbs_seg_plan #(.CNT_W(CNT_W)) u_plan (
    .qaddr_i    (qaddr_q),
    .rem_i      (rem_q),
    .first_i    (rd_idx_q == '0),
    .be_first_i (be_first_q),
    .be_last_i  (be_last_q),
    .mps_sel_i  (mps_sel_i),
    .nb_o       (nb_w),
    .last_o     (seg_last_w),
    .addr_o     (desc_addr_o),
    .len_o      (desc_len_o),
    .fbe_o      (desc_fbe_o),
    .lbe_o      (desc_lbe_o),
    .is64_o     (desc_is64_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_COLLECT;
      idx_q      <= '0;
      cnt_q      <= '0;
      rem_q      <= '0;
      left_q     <= '0;
      rd_idx_q   <= '0;
      qaddr_q    <= '0;
      be_first_q <= '0;
      be_last_q  <= '0;
      bad_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_COLLECT: begin
          if (beat_acc) begin
            be_last_q <= in_be_i;
            if (idx_q == '0) begin
              qaddr_q    <= in_addr_i[63:3];
              cnt_q      <= cnt_now;
              be_first_q <= in_be_i;
            end
            if (last_now) begin
              idx_q <= '0;
              bad_q <= 1'b0;
              if (burst_drop) begin
                err_q <= 1'b1;
              end else begin
                st_q     <= ST_DESC;
                rd_idx_q <= '0;
                rem_q    <= cnt_now;
              end
            end else begin
              idx_q <= idx_q + CNT_W'(1);
              bad_q <= bad_now;
            end
          end
        end
        ST_DESC: begin
          if (desc_fire) begin
            left_q <= nb_w;
            st_q   <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (dat_fire) begin
            rd_idx_q <= rd_idx_q + IDX_W'(1);
            qaddr_q  <= qaddr_q + 61'd1;
            rem_q    <= rem_q - CNT_W'(1);
            left_q   <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1))
              st_q <= (rem_q == CNT_W'(1)) ? ST_COLLECT : ST_DESC;
          end
        end
        default: st_q <= ST_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/wbs_checker.sv
`timescale 1ns/1ps
module wbs_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  mps_sel_i,
  input logic        in_ready_o,
  input logic        desc_valid_o,
  input logic        desc_ready_i,
  input logic [63:0] desc_addr_o,
  input logic [9:0]  desc_len_o,
  input logic [3:0]  desc_fbe_o,
  input logic [3:0]  desc_lbe_o,
  input logic        desc_is64_o,
  input logic        dat_valid_o,
  input logic        dat_ready_i,
  input logic [63:0] dat_o,
  input logic [7:0]  dat_be_o,
  input logic        dat_last_o,
  input logic        err_o,
  input logic        burst_drop
);

  int unsigned lim_bytes;
  always_comb begin
    case (mps_sel_i)
      2'd1:    lim_bytes = 256;
      2'd2:    lim_bytes = 512;
      default: lim_bytes = 128;
    endcase
  end

  // R10: held descriptor
  a_r10_desc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |=> (desc_valid_o && $stable(desc_addr_o) &&
      $stable(desc_len_o) && $stable(desc_fbe_o) && $stable(desc_lbe_o) &&
      $stable(desc_is64_o)));

  // R10: held payload beat
  a_r10_dat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_valid_o && !dat_ready_i) |=> (dat_valid_o && $stable(dat_o) &&
      $stable(dat_be_o) && $stable(dat_last_o)));

  // R10: input stalled while emitting
  a_r10_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o || dat_valid_o) |-> !in_ready_o);

  // R2: page boundary
  a_r2_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (int'(desc_addr_o[11:0]) + int'(desc_len_o) * 4 <= 4096));

  // R3: payload limit
  a_r3_mps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (int'(desc_len_o) * 4 <= int'(lim_bytes)));

  // R5: one-dword packet has no last byte enable
  a_r5_one_dw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_len_o == 10'd1) |-> (desc_lbe_o == 4'd0));

  // R8: drop raises the flag
  a_r8_drop_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_drop |=> err_o);

  // R9: flag is sticky
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R7: only one side active at a time
  a_r7_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_valid_o, dat_valid_o, in_ready_o}));

endmodule

bind wr_burst_segmenter wbs_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mps_sel_i    (mps_sel_i),
  .in_ready_o   (in_ready_o),
  .desc_valid_o (desc_valid_o),
  .desc_ready_i (desc_ready_i),
  .desc_addr_o  (desc_addr_o),
  .desc_len_o   (desc_len_o),
  .desc_fbe_o   (desc_fbe_o),
  .desc_lbe_o   (desc_lbe_o),
  .desc_is64_o  (desc_is64_o),
  .dat_valid_o  (dat_valid_o),
  .dat_ready_i  (dat_ready_i),
  .dat_o        (dat_o),
  .dat_be_o     (dat_be_o),
  .dat_last_o   (dat_last_o),
  .err_o        (err_o),
  .burst_drop   (burst_drop)
);

// File: tb/sim_wr_burst_segmenter.sv
`timescale 1ns/1ps
module sim_wr_burst_segmenter;

  localparam int MB = 64;
  localparam int CW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst_n;
  logic [1:0]    mps_sel;
  logic          in_valid, in_ready;
  logic [63:0]   in_addr, in_data;
  logic [CW-1:0] in_beats;
  logic [7:0]    in_be;
  logic          desc_valid, desc_ready, desc_is64;
  logic [63:0]   desc_addr;
  logic [9:0]    desc_len;
  logic [3:0]    desc_fbe, desc_lbe;
  logic          dat_valid, dat_ready, dat_last;
  logic [63:0]   dat;
  logic [7:0]    dat_be;
  logic          err;

  wr_burst_segmenter #(.MAX_BEATS(MB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mps_sel_i(mps_sel),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_addr_i(in_addr),
    .in_beats_i(in_beats), .in_data_i(in_data), .in_be_i(in_be),
    .desc_valid_o(desc_valid), .desc_ready_i(desc_ready), .desc_addr_o(desc_addr),
    .desc_len_o(desc_len), .desc_fbe_o(desc_fbe), .desc_lbe_o(desc_lbe),
    .desc_is64_o(desc_is64), .dat_valid_o(dat_valid), .dat_ready_i(dat_ready),
    .dat_o(dat), .dat_be_o(dat_be), .dat_last_o(dat_last), .err_o(err)
  );

  int  checks = 0;
  int  fails = 0;
  int  unexpected = 0;
  int  burst_id = 0;
  bit  done = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [82:0] exp_desc[$];
  logic [72:0] exp_dat[$];
  logic [7:0]  bb_be [0:127];
  logic [63:0] bb_dat[0:127];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int lim_bytes(input logic [1:0] s);
    if (s == 2'd1) return 256;
    if (s == 2'd2) return 512;
    return 128;
  endfunction

  function automatic logic [3:0] dw_be(input int beat, input int half);
    return half ? bb_be[beat][7:4] : bb_be[beat][3:0];
  endfunction

  // expected packets, worked out dword by dword
  task automatic model(input logic [63:0] a, input int n, input int cnt);
    bit ok;
    bit seen0;
    logic [63:0] q, ad;
    int i, m, room, lo, hi, ln;
    logic [3:0] fbe, lbe;
    ok = (cnt >= 1) && (cnt <= MB);
    if (ok && n > 1) begin
      for (int b = 0; b < n - 1; b++) if (bb_be[b] != 8'hFF) ok = 0;
      if (!bb_be[n-1][0]) ok = 0;
      seen0 = 0;
      for (int k = 0; k < 8; k++) begin
        if (!bb_be[n-1][k]) seen0 = 1;
        else if (seen0) ok = 0;
      end
    end
    if (!ok) return;
    q = a >> 3;
    i = 0;
    while (i < n) begin
      room = 512 - int'(q[8:0]);
      m = n - i;
      if (room < m) m = room;
      if (lim_bytes(mps_sel) / 8 < m) m = lim_bytes(mps_sel) / 8;
      lo = -1; hi = -1;
      for (int d = 0; d < 2 * m; d++)
        if (dw_be(i + d / 2, d % 2) != 4'd0) begin
          if (lo < 0) lo = d;
          hi = d;
        end
      if (lo < 0) begin
        lo = 0; hi = 0; fbe = 4'd0; lbe = 4'd0;
      end else begin
        fbe = dw_be(i + lo / 2, lo % 2);
        lbe = (hi == lo) ? 4'd0 : dw_be(i + hi / 2, hi % 2);
      end
      ad = q * 8 + 64'(lo * 4);
      ln = hi - lo + 1;
      exp_desc.push_back({(ad[63:32] != 0), ad, 10'(ln), fbe, lbe});
      for (int k = 0; k < m; k++)
        exp_dat.push_back({bb_dat[i + k], bb_be[i + k], (k == m - 1)});
      q = q + 64'(m);
      i = i + m;
    end
  endtask

  task automatic drive(input logic [63:0] a, input int n, input int cnt);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_addr  = a;
      in_beats = CW'(cnt);
      in_data  = bb_dat[b];
      in_be    = bb_be[b];
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input logic [63:0] a, input int n, input int cnt);
    burst_id++;
    for (int b = 0; b < n; b++) bb_dat[b] = {32'(burst_id), 24'h5A5A00, 8'(b)};
    model(a, n, cnt);
    drive(a, n, cnt);
    while (exp_desc.size() != 0 || exp_dat.size() != 0 || !in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // output monitor with random back-pressure
  bit          hold_d = 0, hold_q = 0;
  logic [82:0] prev_d;
  logic [72:0] prev_q;
  always @(negedge clk) begin
    logic [82:0] cd, e;
    logic [72:0] cq, f;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    desc_ready = lfsr[0] | lfsr[3];
    dat_ready  = lfsr[1] | lfsr[5];
    #1;
    if (rst_n) begin
      cd = {desc_is64, desc_addr, desc_len, desc_fbe, desc_lbe};
      cq = {dat, dat_be, dat_last};
      if (hold_d) chk(desc_valid && cd == prev_d, "R10 desc hold", cd, prev_d);
      if (hold_q) chk(dat_valid && cq == prev_q, "R10 data hold", cq, prev_q);
      if (desc_valid || dat_valid) chk(!in_ready, "R10 input stall", in_ready, 0);
      if (desc_valid && desc_ready) begin
        if (exp_desc.size() == 0) begin
          unexpected++;
          chk(0, "R8 unexpected descriptor", cd, 0);
        end else begin
          e = exp_desc.pop_front();
          chk(desc_addr == e[81:18] && desc_len == e[17:8], "R4 split addr/len",
              {desc_addr, desc_len}, {e[81:18], e[17:8]});
          chk(desc_fbe == e[7:4] && desc_lbe == e[3:0], "R5 edge byte enables",
              {desc_fbe, desc_lbe}, e[7:0]);
          chk(desc_is64 == e[82], "R6 address format", desc_is64, e[82]);
        end
        chk(int'(desc_addr[11:0]) + int'(desc_len) * 4 <= 4096, "R2 page crossing",
            {desc_addr, desc_len}, 4096);
        chk(int'(desc_len) * 4 <= lim_bytes(mps_sel), "R3 payload limit",
            desc_len, lim_bytes(mps_sel) / 4);
      end
      if (dat_valid && dat_ready) begin
        if (exp_dat.size() == 0) begin
          unexpected++;
          chk(0, "R7 unexpected data beat", cq, 0);
        end else begin
          f = exp_dat.pop_front();
          chk(cq == f, "R7 payload beat", cq, f);
        end
      end
      hold_d = desc_valid && !desc_ready;
      hold_q = dat_valid && !dat_ready;
      prev_d = cd;
      prev_q = cq;
    end else begin
      hold_d = 0;
      hold_q = 0;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] bases[3];
    logic [63:0] offs[5];
    int          lens[6];
    bases = '{64'h0000_0000_0000_2000, 64'h0000_0001_0000_5000, 64'h0000_0000_FFFF_F000};
    offs  = '{64'h000, 64'hF00, 64'hFC0, 64'hFF8, 64'h7F8};
    lens  = '{1, 2, 16, 17, 33, 64};

    rst_n = 0; mps_sel = 0; in_valid = 0; in_addr = 0; in_beats = 0;
    in_data = 0; in_be = 0; desc_ready = 0; dat_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!desc_valid && !dat_valid && !err && in_ready, "R11 in reset",
        {desc_valid, dat_valid, err, in_ready}, 4'b0001);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!desc_valid && !dat_valid && !err && in_ready, "R11 after reset",
        {desc_valid, dat_valid, err, in_ready}, 4'b0001);

    // R5 R6: every single-beat byte-enable pattern
    for (int v = 0; v < 256; v++) begin
      bb_be[0] = 8'(v);
      run(((v % 2) ? 64'h0000_0002_0000_0000 : 64'h0000_0000_0000_1000) + 64'(v * 8), 1, 1);
    end

    // R1 R2 R3 R4 R6: boundary sweep over all payload settings
    for (int s = 0; s < 4; s++) begin
      mps_sel = 2'(s);
      foreach (bases[bi]) foreach (offs[oi]) foreach (lens[li]) begin
        for (int b = 0; b < lens[li]; b++) bb_be[b] = 8'hFF;
        bb_be[lens[li] - 1] = 8'hFF >> (lens[li] % 8);
        chk(in_ready, "R1 ready between bursts", in_ready, 1);
        run(bases[bi] + offs[oi], lens[li], lens[li]);
      end
    end
    chk(!err, "R9 legal traffic leaves flag low", err, 0);
    chk(unexpected == 0, "R7 no stray output", unexpected, 0);

    // R8: middle beat not full
    mps_sel = 2'd0;
    bb_be[0] = 8'hFF; bb_be[1] = 8'h7F; bb_be[2] = 8'h01;
    run(64'h3000, 3, 3);
    repeat (10) @(negedge clk);
    #1;
    chk(err && unexpected == 0, "R8 middle beat fault dropped", {err, 32'(unexpected)}, 1 << 32);

    // R9: later legal burst still handled, flag stays
    bb_be[0] = 8'hFF; bb_be[1] = 8'h0F;
    run(64'h3FF8, 2, 2);
    chk(err, "R9 flag sticky", err, 1);

    // R8: first beat not full, count 0, count above limit
    bb_be[0] = 8'hFE; bb_be[1] = 8'hFF;
    run(64'h4000, 2, 2);
    bb_be[0] = 8'hFF;
    run(64'h4100, 1, 0);
    for (int b = 0; b < 65; b++) bb_be[b] = 8'hFF;
    run(64'h5000, 65, 65);
    repeat (10) @(negedge clk);
    chk(unexpected == 0, "R8 illegal bursts dropped", unexpected, 0);

    // R5 R8: every last-beat pattern of a two-beat burst
    mps_sel = 2'd1;
    for (int v = 0; v < 256; v++) begin
      bb_be[0] = 8'hFF;
      bb_be[1] = 8'(v);
      run(64'h0000_0000_0000_6000 + 64'(v * 16), 2, 2);
    end
    chk(unexpected == 0, "R8 last beat rule", unexpected, 0);

    // R9 R11: reset clears the flag
    @(negedge clk);
    rst_n = 0;
    @(negedge clk); #1;
    chk(!err && in_ready, "R9 flag cleared by reset", {err, in_ready}, 2'b01);
    rst_n = 1;
    repeat (2) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule